// File: doc/BRIEF.md
# Streak-Demoting Bank Request Scheduler

This block decides, for a single DRAM bank, which waiting request is served next. Two applications push requests (an application number and a row) into an eight-slot holding buffer. The bank serves one request at a time. The block models the service time from the row-buffer state: a request to the row left open by the previous access is quick, and anything else is slow. The next request is chosen in the same cycle that the current one finishes.

To keep one application from taking over the bank, the block counts how many services in a row went to the same application. When that run reaches a threshold set on an input, the application is put on a demotion list. Its requests then lose to those of any application that is not listed. Within the same listing class, row hits win, and after that the oldest arrival wins. The list is wiped on a fixed period of cycles, counted from reset.

Top module: `blist_sched`

## Requirements
- R1: After reset `full`, `iss_valid` and `done` are 0, and with a nonzero threshold `blacklist` is 0. The row buffer starts closed.
- R2: The buffer holds 8 requests. `full` is 1 exactly when 8 are held, and an enqueue offered while `full` is 1 is dropped. An enqueue is accepted at a clock edge when `enq_valid` is 1 and `full` is 0, and it can be selected from the next cycle on.
- R3: The first request served after reset is reported as a row miss (`iss_hit` = 0) and takes the slow latency.
- R4: `done` pulses for one cycle, 50 cycles after the `iss_valid` pulse of a row-hit service and 200 cycles after that of a miss or conflict.
- R5: `iss_valid` pulses in the same cycle as `done` when a request is waiting at that moment. With an idle bank it pulses one cycle after the request's enqueue edge.
- R6: If any waiting request belongs to an application with its `blacklist` bit at 0, the request served is one of those.
- R7: Among requests of equal listing class, a request whose row equals the row of the previous service is served before one that does not.
- R8: Among requests equal in listing class and in hit status, the earliest accepted is served first.
- R9: Each service extends a run counter when its application matches the previous service's application, and otherwise restarts the counter at 1. The counter saturates at 15. When a service leaves the counter at or above a nonzero `threshold`, that application's `blacklist` bit (bit index = application number) is 1 from the cycle of its `iss_valid` pulse.
- R10: With `threshold` = 0, both `blacklist` bits read 1 and all requests compete as listed.
- R11: Stored listing bits are cleared at every 10000th clock edge after reset. The clear overrides a listing caused by a service at that same edge.
- R12: `iss_hit` is 1 exactly when the served row equals the row of the previous service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a new request |
| enq_app | input | 1 | Application number of the offered request |
| enq_row | input | 4 | Row of the offered request |
| threshold | input | 4 | Run length that triggers listing; 0 lists everyone |
| full | output | 1 | Buffer holds 8 requests |
| iss_valid | output | 1 | One-cycle pulse: a request starts service |
| iss_app | output | 1 | Application of the request started |
| iss_row | output | 4 | Row of the request started |
| iss_hit | output | 1 | The request started hits the open row |
| done | output | 1 | One-cycle pulse: the service in progress completes |
| blacklist | output | 2 | Per-application listing status |

## Verification
An issue and a listing change caused by it appear one cycle after the selecting edge. A completion appears exactly 50 or 200 cycles after its issue pulse. A periodic clear shows in the cycle after the edge on which it occurs. `full` reflects an accepted enqueue one cycle after its edge. The bench keeps a reference model that steps on the same rising edge as the design, using only the inputs it drives. It drives those inputs just after the rising edge and compares every output at the falling edge, so each expected value lines up with the cycle in which the design's registered outputs change.

// File: rtl/blist_pkg.sv
package blist_pkg;
  localparam int SEQ_W = 16;

  // a arrived before b (modular arrival numbers)
  function automatic logic seq_before(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic int unsigned svc_cycles(input logic hit, input int unsigned hit_lat,
                                             input int unsigned miss_lat);
    return hit ? hit_lat : miss_lat;
  endfunction

  // higher is more urgent: unlisted beats listed, then row hit
  function automatic logic [1:0] rank_of(input logic listed, input logic hit);
    return {~listed, hit};
  endfunction

  function automatic int unsigned next_run(input logic same, input int unsigned cur,
                                           input int unsigned cap);
    if (!same) return 1;
    return (cur >= cap) ? cap : cur + 1;
  endfunction

  typedef enum logic {BANK_IDLE, BANK_BUSY} bank_st_e;
endpackage

// File: rtl/blist_req_buf.sv
module blist_req_buf
  import blist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int APP_W = 1,
  parameter int ROW_W = 4,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               enq_valid,
  input  logic [APP_W-1:0]                   enq_app,
  input  logic [ROW_W-1:0]                   enq_row,
  input  logic                               free_en,
  input  logic [IDX_W-1:0]                   free_idx,
  output logic [DEPTH-1:0]                   vld,
  output logic [DEPTH-1:0][APP_W-1:0]        apps,
  output logic [DEPTH-1:0][ROW_W-1:0]        rows,
  output logic [DEPTH-1:0][SEQ_W-1:0]        seqs,
  output logic                               full
);
  logic [IDX_W-1:0] alloc_idx;
  logic [SEQ_W-1:0] seq_ctr;
  logic             accept;

  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) alloc_idx = IDX_W'(i);
  end

  assign full   = &vld;
  assign accept = enq_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      apps    <= '0;
      rows    <= '0;
      seqs    <= '0;
      seq_ctr <= '0;
    end else begin
      if (free_en) vld[free_idx] <= 1'b0;
      if (accept) begin
        vld[alloc_idx]  <= 1'b1;
        apps[alloc_idx] <= enq_app;
        rows[alloc_idx] <= enq_row;
        seqs[alloc_idx] <= seq_ctr;
        seq_ctr         <= seq_ctr + 1'b1;
      end
    end
  end

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !free_en) |=> full);
  // R2
  free_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> vld[free_idx]);
endmodule

// File: rtl/blist_pick.sv
module blist_pick
  import blist_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NUM_APPS = 2,
  parameter int APP_W    = 1,
  parameter int ROW_W    = 4,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][APP_W-1:0] apps,
  input  logic [DEPTH-1:0][ROW_W-1:0] rows,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
  input  logic [NUM_APPS-1:0]         listed,
  input  logic                        row_open,
  input  logic [ROW_W-1:0]            open_row,
  output logic                        sel_valid,
  output logic [IDX_W-1:0]            sel_idx,
  output logic                        sel_hit
);
  logic             unlisted_waiting;
  logic [1:0]       best_rank;
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    logic       hit_i;
    logic [1:0] rk;
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_hit   = 1'b0;
    best_rank = '0;
    best_seq  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_i = row_open && (rows[i] == open_row);
      rk    = rank_of(listed[apps[i]], hit_i);
      if (vld[i] && (!sel_valid || rk > best_rank ||
                     (rk == best_rank && seq_before(seqs[i], best_seq)))) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        sel_hit   = hit_i;
        best_rank = rk;
        best_seq  = seqs[i];
      end
    end
  end

  always_comb begin
    unlisted_waiting = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && !listed[apps[i]]) unlisted_waiting = 1'b1;
  end

  // R6
  unlisted_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlisted_waiting |-> !listed[apps[sel_idx]]);
  // R5
  pick_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> vld[sel_idx]);
endmodule

// File: rtl/blist_track.sv
module blist_track
  import blist_pkg::*;
#(
  parameter int NUM_APPS     = 2,
  parameter int APP_W        = 1,
  parameter int THR_W        = 4,
  parameter int CLEAR_PERIOD = 10000,
  parameter int PER_W        = $clog2(CLEAR_PERIOD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue,
  input  logic [APP_W-1:0]    issue_app,
  input  logic [THR_W-1:0]    threshold,
  output logic [NUM_APPS-1:0] listed
);
  localparam int unsigned RUN_CAP = (1 << THR_W) - 1;

  logic [PER_W-1:0]    per_cnt;
  logic                clr_now;
  logic [THR_W-1:0]    run_len;
  logic [APP_W-1:0]    last_app;
  logic                have_last;
  logic [NUM_APPS-1:0] bl_q, bl_n;
  logic [THR_W-1:0]    run_n;

  assign clr_now = (per_cnt == PER_W'(CLEAR_PERIOD - 1));
  assign run_n   = THR_W'(next_run(have_last && (last_app == issue_app), run_len, RUN_CAP));

  always_comb begin
    bl_n = bl_q;
    if (issue && threshold != '0 && run_n >= threshold) bl_n[issue_app] = 1'b1;
    if (clr_now) bl_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt   <= '0;
      run_len   <= '0;
      last_app  <= '0;
      have_last <= 1'b0;
      bl_q      <= '0;
    end else begin
      per_cnt <= clr_now ? '0 : per_cnt + 1'b1;
      bl_q    <= bl_n;
      if (issue) begin
        run_len   <= run_n;
        last_app  <= issue_app;
        have_last <= 1'b1;
      end
    end
  end

  assign listed = bl_q | {NUM_APPS{threshold == '0}};

  // R11
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (bl_q == '0));
  // R9
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && have_last && issue_app != last_app) |=> (run_len == THR_W'(1)));
  // R10
  zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (threshold == '0) |=> ($stable(bl_q) || bl_q == '0));
endmodule

// File: rtl/blist_bank_timer.sv
module blist_bank_timer
  import blist_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int HIT_LAT  = 50,
  parameter int MISS_LAT = 200,
  parameter int CNT_W    = $clog2(MISS_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [ROW_W-1:0] issue_row,
  input  logic             issue_hit,
  output logic             bank_free,
  output logic             finishing,
  output logic             done,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row
);
  bank_st_e         st;
  logic [CNT_W-1:0] cnt;

  assign finishing = (st == BANK_BUSY) && (cnt == '0);
  assign bank_free = (st == BANK_IDLE) || finishing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= BANK_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      row_open <= 1'b0;
      open_row <= '0;
    end else begin
      done <= finishing;
      if (issue) begin
        st       <= BANK_BUSY;
        cnt      <= CNT_W'(svc_cycles(issue_hit, HIT_LAT, MISS_LAT) - 1);
        row_open <= 1'b1;
        open_row <= issue_row;
      end else if (finishing) begin
        st <= BANK_IDLE;
      end else if (st == BANK_BUSY) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R3
  closed_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !row_open) |-> !issue_hit);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/blist_sched.sv
module blist_sched
  import blist_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int NUM_APPS     = 2,
  parameter int APP_W        = 1,
  parameter int ROW_W        = 4,
  parameter int THR_W        = 4,
  parameter int HIT_LAT      = 50,
  parameter int MISS_LAT     = 200,
  parameter int CLEAR_PERIOD = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  input  logic [APP_W-1:0]    enq_app,
  input  logic [ROW_W-1:0]    enq_row,
  input  logic [THR_W-1:0]    threshold,
  output logic                full,
  output logic                iss_valid,
  output logic [APP_W-1:0]    iss_app,
  output logic [ROW_W-1:0]    iss_row,
  output logic                iss_hit,
  output logic                done,
  output logic [NUM_APPS-1:0] blacklist
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(MISS_LAT + 1);

  logic [DEPTH-1:0]            vld;
  logic [DEPTH-1:0][APP_W-1:0] apps;
  logic [DEPTH-1:0][ROW_W-1:0] rows;
  logic [DEPTH-1:0][SEQ_W-1:0] seqs;
  logic                        sel_valid, sel_hit;
  logic [IDX_W-1:0]            sel_idx;
  logic                        bank_free, finishing, row_open;
  logic [ROW_W-1:0]            open_row;
  logic                        issue;

  assign issue = bank_free && sel_valid;

  blist_req_buf #(.DEPTH(DEPTH), .APP_W(APP_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_app(enq_app), .enq_row(enq_row),
    .free_en(issue), .free_idx(sel_idx), .vld(vld), .apps(apps), .rows(rows), .seqs(seqs),
    .full(full));

  blist_pick #(.DEPTH(DEPTH), .NUM_APPS(NUM_APPS), .APP_W(APP_W), .ROW_W(ROW_W),
               .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .vld(vld), .apps(apps), .rows(rows), .seqs(seqs),
    .listed(blacklist), .row_open(row_open), .open_row(open_row),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_hit(sel_hit));

  blist_track #(.NUM_APPS(NUM_APPS), .APP_W(APP_W), .THR_W(THR_W),
                .CLEAR_PERIOD(CLEAR_PERIOD)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_app(apps[sel_idx]),
    .threshold(threshold), .listed(blacklist));

  blist_bank_timer #(.ROW_W(ROW_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) u_bank (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_row(rows[sel_idx]), .issue_hit(sel_hit),
    .bank_free(bank_free), .finishing(finishing), .done(done), .row_open(row_open),
    .open_row(open_row));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_app   <= '0;
      iss_row   <= '0;
      iss_hit   <= 1'b0;
    end else begin
      iss_valid <= issue;
      if (issue) begin
        iss_app <= apps[sel_idx];
        iss_row <= rows[sel_idx];
        iss_hit <= sel_hit;
      end
    end
  end

  // independent service-length watcher for the latency assertion
  logic [CNT_W:0] since_iss;
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_iss <= '0;
      lat_q     <= '0;
    end else if (issue) begin
      since_iss <= (CNT_W+1)'(1);
      lat_q     <= (CNT_W+1)'(svc_cycles(sel_hit, HIT_LAT, MISS_LAT));
    end else if (since_iss != '1) begin
      since_iss <= since_iss + 1'b1;
    end
  end

  // R4
  svc_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finishing |-> (since_iss == lat_q));
  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && vld != '0) |=> (iss_valid && done));
  // R12
  hit_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_hit) |-> (iss_row == $past(open_row)));
endmodule

// File: tb/blist_sched_tb.sv
module blist_sched_tb;
  localparam int CLK_P = 10;
  localparam int CLR   = 10000;
  localparam int DEP   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0;
  logic       enq_app = 1'b0;
  logic [3:0] enq_row = '0;
  logic [3:0] threshold = 4'd3;
  logic       full, iss_valid, iss_app, iss_hit, done;
  logic [3:0] iss_row;
  logic [1:0] blacklist;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  blist_sched u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_app(enq_app), .enq_row(enq_row),
    .threshold(threshold), .full(full), .iss_valid(iss_valid), .iss_app(iss_app),
    .iss_row(iss_row), .iss_hit(iss_hit), .done(done), .blacklist(blacklist));

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model state
  bit    mv[DEP];
  int    ma[DEP], mr[DEP], ms[DEP];
  int    m_seq, m_busy, m_cnt, m_pcnt, m_streak, m_last, m_orow;
  bit    m_have, m_open, m_started, m_clr;
  bit [1:0] m_bl, m_eb;
  bit    e_iss, e_hit, e_done, e_first;
  int    e_app, e_row, m_pre, best, brk, bs, rk, nb, nbl, nh, nm;
  bit    bh, h, m_free;
  string e_tag;

  function automatic int lat_for(input bit hit);
    return hit ? 50 : 200;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[i]) mv[i] = 0;
      m_seq = 0; m_busy = 0; m_cnt = 0; m_pcnt = 0; m_streak = 0; m_last = 0;
      m_have = 0; m_open = 0; m_orow = 0; m_started = 0; m_bl = 0; m_clr = 0;
      e_iss = 0; e_done = 0; e_hit = 0; e_first = 0; e_tag = "R8";
    end else begin
      m_free = (m_busy == 0) || (m_cnt == 0);
      e_done = (m_busy != 0) && (m_cnt == 0);
      e_iss = 0; m_clr = 0;
      m_pre = 0;
      for (int i = 0; i < DEP; i++) m_pre += mv[i];
      for (int a = 0; a < 2; a++) m_eb[a] = m_bl[a] | (threshold == 0);
      if (m_free && m_pre > 0) begin
        best = -1; brk = 0; bs = 0; bh = 0; nb = 0; nbl = 0; nh = 0; nm = 0;
        for (int i = 0; i < DEP; i++) if (mv[i]) begin
          h  = m_open && (mr[i] == m_orow);
          rk = (m_eb[ma[i]] ? 0 : 2) + (h ? 1 : 0);
          if (m_eb[ma[i]]) nbl++; else nb++;
          if (h) nh++; else nm++;
          if (best < 0 || rk > brk || (rk == brk && ms[i] < bs)) begin
            best = i; brk = rk; bs = ms[i]; bh = h;
          end
        end
        e_tag = (nb > 0 && nbl > 0) ? "R6" : ((nh > 0 && nm > 0) ? "R7" : "R8");
        e_iss = 1; e_app = ma[best]; e_row = mr[best]; e_hit = bh;
        e_first = !m_started; m_started = 1;
        mv[best] = 0;
        m_streak = (m_have && m_last == e_app) ? ((m_streak >= 15) ? 15 : m_streak + 1) : 1;
        m_last = e_app; m_have = 1;
        if (threshold != 0 && m_streak >= threshold) m_bl[e_app] = 1;
        m_open = 1; m_orow = e_row; m_busy = 1; m_cnt = lat_for(bh) - 1;
      end else if (e_done) begin
        m_busy = 0;
      end else if (m_busy != 0) begin
        m_cnt--;
      end
      if (m_pcnt == CLR - 1) begin m_bl = 0; m_pcnt = 0; m_clr = 1; end
      else m_pcnt++;
      if (enq_valid && m_pre < DEP) begin
        for (int i = 0; i < DEP; i++) if (!mv[i]) begin
          mv[i] = 1; ma[i] = enq_app; mr[i] = enq_row; ms[i] = m_seq; m_seq++;
          break;
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int cnt_now;
      cnt_now = 0;
      for (int i = 0; i < DEP; i++) cnt_now += mv[i];
      check("R2 full", full, cnt_now == DEP);
      check("R5 issue timing", iss_valid, e_iss);
      check("R4 completion", done, e_done);
      if (e_iss && iss_valid) begin
        check({e_tag, " app"}, iss_app, e_app);
        check({e_tag, " row"}, iss_row, e_row);
        check(e_first ? "R3 first miss" : "R12 hit flag", iss_hit, e_hit);
      end
      check((threshold == 0) ? "R10 all listed" : (m_clr ? "R11 clear" : "R9 listing"),
            blacklist, m_bl | ((threshold == 0) ? 2'b11 : 2'b00));
    end
  end

  task automatic run_phase(input int thr_v, input int cycles, input int enq_pct,
                           input int app0_pct, input int row_span);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      #1;
      threshold = 4'(thr_v);
      enq_valid = ($urandom % 100) < enq_pct;
      enq_app   = (($urandom % 100) < app0_pct) ? 1'b0 : 1'b1;
      enq_row   = 4'($urandom % row_span);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    threshold = 4'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 full", full, 0);
    check("R1 iss_valid", iss_valid, 0);
    check("R1 done", done, 0);
    check("R1 blacklist", blacklist, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // directed: single request on idle bank, closed row -> miss (R3, R5)
    run_phase(3, 1, 100, 100, 1);
    run_phase(3, 260, 0, 50, 1);
    // directed: same row again -> hit latency (R4, R12)
    run_phase(3, 1, 100, 100, 1);
    run_phase(3, 120, 0, 50, 1);
    run_phase(3, 4000, 60, 50, 4);   // mixed traffic, hits and conflicts
    run_phase(0, 3000, 60, 50, 3);   // R10 zero threshold
    run_phase(1, 2500, 50, 50, 4);
    run_phase(2, 3000, 2, 70, 2);    // sparse: idle bank path
    run_phase(6, 13500, 70, 85, 3);  // long runs of one app, crosses clears (R11)
    enq_valid = 1'b0;
    repeat (500) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      finish_run();
    end
  end
endmodule